// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital core of a 16-bit successive-approximation converter. It turns two active-low control inputs, a chip-select and a read/convert line, into conversion starts and read enables. It then runs the bit search against a one-bit comparator decision and signals progress on an active-low busy flag. At the end it latches the result and presents it on a tri-state parallel bus whose two bytes can be exchanged. The analog parts are outside the block: the sampler, the capacitive DAC, the comparator and the reference. The DAC is driven from `dac_code_o`, the comparator answer comes back on `cmp_i`, and the conversion clock is the plain clock input.

The two control inputs are combined with an OR. When the combined line is held low, a conversion starts, whichever of the two pins fell last. When chip-select is low and read/convert is high, the bus is driven. A parameter chooses straight-binary or two's-complement output coding.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts when the OR of `cs_ni` and `rc_ni` has been sampled low on MIN_PULSE consecutive rising edges while the block is idle. `busy_no` falls after the next edge. A shorter low pulse starts nothing, and holding `cs_ni` high with `rc_ni` low starts nothing.
- R2: At start, `dac_code_o` holds only its MSB set (0x8000). On each following cycle the bit under trial is kept if `cmp_i` is 1 and cleared if it is 0, and the next lower bit becomes the new trial, from MSB down to LSB. With a comparator that returns 1 when the input is at or above the trial code, the result equals the input.
- R3: `busy_no` stays low for exactly WIDTH+1 cycles: one cycle per bit decision plus one latch-load cycle. The output latch changes only at the edge where `busy_no` rises.
- R4: A start condition raised while a conversion is running has no effect on the result or on the busy timing.
- R5: If the start condition is still low at the edge where `busy_no` rises, `busy_no` stays high for exactly one cycle and a new conversion begins with `dac_code_o` = 0x8000. No acquisition time is given.
- R6: In all other cases, `busy_no` stays high for at least ACQ_CYCLES+1 cycles. A request made right after the rise starts the next conversion at the (ACQ_CYCLES+1)-th edge after the rise.
- R7: `data_oe_o` is 1 only while `cs_ni` is 0 and `rc_ni` is 1, and it follows those pins without a clock. Otherwise `data_o` is high-impedance.
- R8: With `byte_swap_i` at 0, latch bits [15:8] appear on `data_o[15:8]` and bits [7:0] on `data_o[7:0]`. With `byte_swap_i` at 1, the two bytes are exchanged.
- R9: With BIPOLAR=0 the search result is output unchanged (straight binary). With BIPOLAR=1 its MSB is inverted (two's complement): input 0x0000 gives 0x8000, 0xFFFF gives 0x7FFF, and 0x8000 gives 0x0000.
- R10: After reset, `busy_no` is 1, `dac_code_o` is 0, the output latch is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select, active low |
| rc_ni | input | 1 | Read (high) / convert (low) control |
| byte_swap_i | input | 1 | Exchange the upper and lower output bytes |
| cmp_i | input | 1 | Comparator decision, 1 = input at or above trial code |
| busy_no | output | 1 | Low while a conversion runs |
| dac_code_o | output | WIDTH | Trial code for the capacitive DAC |
| data_oe_o | output | 1 | Bus drive enable |
| data_o | output | WIDTH | Tri-state result bus |

## Verification
Take the first rising edge that samples the start condition low as edge 1. `busy_no` is then due low after edge MIN_PULSE+1 and high again WIDTH+1 edges later. At that high edge the new word is already on the bus. The bench counts clock edges from each stimulus and samples on the falling edge at exactly these points. On a retrigger the busy-high gap is one cycle; after a fresh request it is ACQ_CYCLES+1 cycles, and the bench checks the cycle on each side of each boundary. Bus enable and byte exchange need no clock, so the bench checks them a short delay after it changes the pins, before the next rising edge.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_LOAD = 2'd2,
    ST_ACQ  = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_start_qual.sv
module sar_start_qual #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rc_ni,
  output logic start_req_o,
  output logic rd_en_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_PULSE);

  logic          ctl_low;
  logic [CW-1:0] low_cnt_q;

  // OR-combined active-low control
  assign ctl_low = ~(cs_ni | rc_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 low_cnt_q <= '0;
    else if (!ctl_low)           low_cnt_q <= '0;
    else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + CW'(1);
  end

  assign start_req_o = (low_cnt_q == CNT_MAX);
  assign rd_en_o     = ~cs_ni & rc_ni;
endmodule

// File: rtl/sar_seq.sv
module sar_seq import sar_ctrl_pkg::*; #(
  parameter int WIDTH      = 16,
  parameter int ACQ_CYCLES = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_req_i,
  input  logic             cmp_i,
  output logic             busy_no,
  output logic             load_o,
  output logic [WIDTH-1:0] trial_o
);
  localparam int IW = $clog2(WIDTH);
  localparam int AW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [WIDTH-1:0] MSB_TRIAL = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [IW-1:0]    TOP_IDX   = IW'(WIDTH - 1);
  localparam logic [AW-1:0]    ACQ_LAST  = AW'(ACQ_CYCLES - 1);

  sar_state_e       state_q;
  logic [IW-1:0]    idx_q;
  logic [WIDTH-1:0] sar_q;
  logic [WIDTH-1:0] decided;
  logic [AW-1:0]    acq_q;

  // Resolve current trial bit, arm the next lower one
  always_comb begin
    decided = sar_q;
    decided[idx_q] = cmp_i;
    if (idx_q != '0) decided[idx_q - IW'(1)] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sar_q   <= '0;
      acq_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_req_i) begin
          state_q <= ST_CONV;
          sar_q   <= MSB_TRIAL;
          idx_q   <= TOP_IDX;
        end
        ST_CONV: begin
          sar_q <= decided;
          if (idx_q == '0) state_q <= ST_LOAD;
          else             idx_q   <= idx_q - IW'(1);
        end
        ST_LOAD: begin
          state_q <= ST_ACQ;
          acq_q   <= '0;
        end
        ST_ACQ: begin
          if (acq_q == '0 && start_req_i) begin
            // control still low as busy rises: no acquisition time
            state_q <= ST_CONV;
            sar_q   <= MSB_TRIAL;
            idx_q   <= TOP_IDX;
          end else if (acq_q == ACQ_LAST) begin
            state_q <= ST_IDLE;
          end else begin
            acq_q <= acq_q + AW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_no = ~((state_q == ST_CONV) || (state_q == ST_LOAD));
  assign load_o  = (state_q == ST_LOAD);
  assign trial_o = sar_q;
endmodule

// File: rtl/sar_out_port.sv
module sar_out_port #(
  parameter int WIDTH   = 16,
  parameter bit BIPOLAR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] result_i,
  input  logic             swap_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] word_o,
  output logic [WIDTH-1:0] latch_o,
  output logic             oe_o
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] coded;
  logic [WIDTH-1:0] latch_q;

  generate
    if (BIPOLAR) begin : g_bip
      assign coded = {~result_i[WIDTH-1], result_i[WIDTH-2:0]};
    end else begin : g_uni
      assign coded = result_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= '0;
    else if (load_i) latch_q <= coded;
  end

  assign word_o  = swap_i ? {latch_q[HALF-1:0], latch_q[WIDTH-1:HALF]} : latch_q;
  assign latch_o = latch_q;
  assign oe_o    = rd_en_i;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH      = 16,
  parameter int MIN_PULSE  = 4,
  parameter int ACQ_CYCLES = 100,
  parameter bit BIPOLAR    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rc_ni,
  input  logic             byte_swap_i,
  input  logic             cmp_i,
  output logic             busy_no,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             data_oe_o,
  output logic [WIDTH-1:0] data_o
);
  logic             start_req;
  logic             rd_en;
  logic             load;
  logic [WIDTH-1:0] word;
  logic [WIDTH-1:0] latch_w;

  sar_start_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .rc_ni       (rc_ni),
    .start_req_o (start_req),
    .rd_en_o     (rd_en)
  );

  sar_seq #(.WIDTH(WIDTH), .ACQ_CYCLES(ACQ_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_req_i (start_req),
    .cmp_i       (cmp_i),
    .busy_no     (busy_no),
    .load_o      (load),
    .trial_o     (dac_code_o)
  );

  sar_out_port #(.WIDTH(WIDTH), .BIPOLAR(BIPOLAR)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .result_i (dac_code_o),
    .swap_i   (byte_swap_i),
    .rd_en_i  (rd_en),
    .word_o   (word),
    .latch_o  (latch_w),
    .oe_o     (data_oe_o)
  );

  assign data_o = data_oe_o ? word : 'z;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int WIDTH      = 16,
  parameter int ACQ_CYCLES = 100
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             rc_ni,
  input logic             busy_no,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] latch_i
);
  localparam int LW = $clog2(WIDTH + 2) + 1;
  localparam int HW = $clog2(ACQ_CYCLES + 2) + 1;
  localparam logic [LW-1:0] LOW_LEN = LW'(WIDTH + 1);
  localparam logic [HW-1:0] GAP_MIN = HW'(ACQ_CYCLES + 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [LW-1:0] low_run_q;
  logic [HW-1:0] high_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q  <= '0;
      high_run_q <= GAP_MIN;
    end else if (!busy_no) begin
      high_run_q <= '0;
      if (low_run_q != '1) low_run_q <= low_run_q + LW'(1);
    end else begin
      low_run_q <= '0;
      if (high_run_q < GAP_MIN) high_run_q <= high_run_q + HW'(1);
    end
  end

  a_r3_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> low_run_q == LOW_LEN);

  a_r3_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && $past(!busy_no)) |-> $stable(latch_i));

  a_r1_start_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no) |-> !$past(cs_ni | rc_ni, 2));

  a_r2_sar_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no) |-> dac_code_o == MSB_ONLY);

  // R5 / R6: either an immediate retrigger or a full acquisition gap
  a_r6_acq_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no) |-> (high_run_q == HW'(1) || high_run_q >= GAP_MIN));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH), .ACQ_CYCLES(ACQ_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .rc_ni      (rc_ni),
  .busy_no    (busy_no),
  .dac_code_o (dac_code_o),
  .latch_i    (latch_w)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
  localparam int W   = 16;
  localparam int M   = 3;
  localparam int ACQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rc_n = 1'b1;
  logic bsel = 1'b0;
  logic [W-1:0] vin = '0;

  logic busy_u, busy_b, oe_u, oe_b, cmp_u, cmp_b;
  logic [W-1:0] dac_u, dac_b, data_u, data_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign cmp_u = (dac_u <= vin);
  assign cmp_b = (dac_b <= vin);

  sar_conv_ctrl #(.WIDTH(W), .MIN_PULSE(M), .ACQ_CYCLES(ACQ), .BIPOLAR(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rc_ni(rc_n), .byte_swap_i(bsel),
    .cmp_i(cmp_u), .busy_no(busy_u), .dac_code_o(dac_u), .data_oe_o(oe_u), .data_o(data_u));

  sar_conv_ctrl #(.WIDTH(W), .MIN_PULSE(M), .ACQ_CYCLES(ACQ), .BIPOLAR(1'b1)) u_dut_bip (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rc_ni(rc_n), .byte_swap_i(bsel),
    .cmp_i(cmp_b), .busy_no(busy_b), .dac_code_o(dac_b), .data_oe_o(oe_b), .data_o(data_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // from the negedge after the start edge: W+1 cycles low, then data
  task automatic conv_tail(input logic [W-1:0] v);
    repeat (W) @(negedge clk);
    chk("R3 busy low through load", 32'(busy_u), 32'd0);
    @(negedge clk);
    chk("R3 busy high after load", 32'(busy_u), 32'd1);
    chk("R2 unipolar result", 32'(data_u), 32'(v));
    chk("R9 bipolar result", 32'(data_b), 32'(v ^ 16'h8000));
  endtask

  task automatic convert(input logic [W-1:0] v);
    vin = v;
    @(negedge clk); cs_n = 1'b0; rc_n = 1'b0;
    repeat (M) @(negedge clk);
    chk("R1 no start before min pulse", 32'(busy_u), 32'd1);
    @(negedge clk);
    chk("R1 busy low after min pulse", 32'(busy_u), 32'd0);
    chk("R2 sar cleared to msb trial", 32'(dac_u), 32'h8000);
    rc_n = 1'b1;
    conv_tail(v);
    repeat (ACQ + 1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 busy high in reset", 32'(busy_u), 32'd1);
    chk("R10 dac zero in reset", 32'(dac_u), 32'd0);
    chk("R7 no drive with cs high", 32'(oe_u), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; rc_n = 1'b1;
    #1;
    chk("R10 latch zero after reset", 32'(data_u), 32'd0);
    chk("R7 drive with cs low rc high", 32'(oe_u), 32'd1);

    // R7 enable decode, no clock edge crossed
    @(negedge clk);
    cs_n = 1'b1; rc_n = 1'b1; #1;
    chk("R7 cs high rc high", 32'(oe_u), 32'd0);
    cs_n = 1'b1; rc_n = 1'b0; #1;
    chk("R7 cs high rc low", 32'(oe_u), 32'd0);
    cs_n = 1'b0; rc_n = 1'b0; #1;
    chk("R7 cs low rc low", 32'(oe_u), 32'd0);
    cs_n = 1'b0; rc_n = 1'b1; #1;
    chk("R7 cs low rc high", 32'(oe_b), 32'd1);

    // R1 short pulse
    @(negedge clk); rc_n = 1'b0;
    repeat (M - 1) @(negedge clk);
    rc_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 short pulse ignored", 32'(busy_u), 32'd1);
    end

    // R2 / R9 corners
    convert(16'h0000);
    convert(16'hFFFF);
    convert(16'h8000);
    convert(16'h7FFF);
    convert(16'h0001);
    convert(16'h12AB);

    // R8 byte exchange
    bsel = 1'b1; #1;
    chk("R8 swapped unipolar", 32'(data_u), 32'h0000AB12);
    chk("R8 swapped bipolar", 32'(data_b), 32'h0000AB92);
    bsel = 1'b0; #1;
    chk("R8 straight order", 32'(data_u), 32'h000012AB);

    // R1 chip-select driven start, read/convert low first
    @(negedge clk); cs_n = 1'b1; rc_n = 1'b0; vin = 16'hC3A5;
    repeat (5) @(negedge clk);
    chk("R1 cs high holds off start", 32'(busy_u), 32'd1);
    cs_n = 1'b0;
    repeat (M) @(negedge clk);
    chk("R1 cs start not early", 32'(busy_u), 32'd1);
    @(negedge clk);
    chk("R1 cs start", 32'(busy_u), 32'd0);
    rc_n = 1'b1;
    conv_tail(16'hC3A5);
    repeat (ACQ + 1) @(negedge clk);

    // R4 restart attempt mid-conversion
    vin = 16'h5A3C;
    @(negedge clk); cs_n = 1'b0; rc_n = 1'b0;
    repeat (M + 1) @(negedge clk);
    chk("R4 started", 32'(busy_u), 32'd0);
    rc_n = 1'b1;
    @(negedge clk); rc_n = 1'b0;
    repeat (M + 2) @(negedge clk);
    rc_n = 1'b1;
    repeat (W - 1 - (M + 2)) @(negedge clk);
    chk("R4 busy still low", 32'(busy_u), 32'd0);
    @(negedge clk);
    chk("R4 busy rise unchanged", 32'(busy_u), 32'd1);
    chk("R4 result unchanged", 32'(data_u), 32'h5A3C);
    repeat (ACQ + 1) @(negedge clk);

    // R5 held low through busy rise
    vin = 16'h3141;
    @(negedge clk); cs_n = 1'b0; rc_n = 1'b0;
    repeat (M + 1) @(negedge clk);
    chk("R5 first start", 32'(busy_u), 32'd0);
    repeat (W) @(negedge clk);
    chk("R5 first busy low", 32'(busy_u), 32'd0);
    @(negedge clk);
    chk("R5 busy high one cycle", 32'(busy_u), 32'd1);
    vin = 16'hE07F;
    @(negedge clk);
    chk("R5 retriggered", 32'(busy_u), 32'd0);
    chk("R5 retrigger msb trial", 32'(dac_u), 32'h8000);
    rc_n = 1'b1; #1;
    chk("R5 first result kept", 32'(data_u), 32'h3141);
    conv_tail(16'hE07F);

    // R6 request right after busy rise waits for acquisition
    vin = 16'h0F0F;
    cs_n = 1'b0; rc_n = 1'b0;
    repeat (ACQ) @(negedge clk);
    chk("R6 acquisition holds off", 32'(busy_u), 32'd1);
    @(negedge clk);
    chk("R6 start after acquisition", 32'(busy_u), 32'd0);
    rc_n = 1'b1;
    conv_tail(16'h0F0F);
    repeat (ACQ + 1) @(negedge clk);

    // R2 / R9 sweep
    for (int i = 0; i < 1000; i++) convert(16'(i * 65 + 13));

    summary();
  end
endmodule